// File: doc/BRIEF.md
# Ternary Match Table

This block is a 32-entry ternary lookup table meant to serve as the match stage of a packet filter. Each slot holds a 32-bit pattern, a 32-bit ignore mask and a 5-bit action code. A set mask bit makes the corresponding pattern bit a wildcard. A write port fills a slot or clears it. A lookup port accepts a 32-bit search key under a valid/ready handshake. All valid slots compare against the key in parallel. The lowest-numbered matching slot wins.

The lookup is fully pipelined, so it accepts a new key every cycle. Two clock cycles after a key is accepted, the block returns one registered result. The result carries the winning slot number and its action code, or it raises a miss flag. A control plane fills the table through the write port while the data path streams keys into the lookup port.

Top module: `tern_match_table`

## Requirements
- R1: After reset every slot is invalid, so every lookup returns a miss until a slot is written.
- R2: A write with `wr_en` high and `wr_clear` low commits key, mask and action to slot `wr_idx` at the clock edge. A later lookup of that exact key returns that slot number and action with `res_miss` low.
- R3: A mask bit at 1 excludes that key bit from the comparison. A mask bit at 0 requires the search bit to equal the stored bit.
- R4: A write with `wr_en` and `wr_clear` both high invalidates slot `wr_idx`. The slot then stops matching, whatever its stored key and mask.
- R5: A lookup that matches no valid slot returns `res_miss` = 1 with `res_idx` = 0 and `res_act` = 0.
- R6: When several valid slots match, the result names the slot with the lowest index and returns that slot's action.
- R7: A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. Its result appears with `res_valid` high for exactly one cycle, two cycles later. Back-to-back lookups return results in request order.
- R8: `lk_ready` is low while reset is applied and is high in every cycle once reset has been released and synchronised.
- R9: A write and a lookup in the same cycle are both performed. The lookup is answered from the table contents before that write.
- R10: Writing an already valid slot replaces its key, mask and action entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit a table write this cycle |
| wr_clear | input | 1 | With `wr_en`, invalidate the slot instead of loading it |
| wr_idx | input | 5 | Slot number to write or clear |
| wr_act | input | 5 | Action code to store |
| wr_key | input | 32 | Pattern to store |
| wr_mask | input | 32 | Ignore mask to store (1 = don't care) |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_key | input | 32 | Search key |
| res_valid | output | 1 | Result present (one cycle per lookup) |
| res_miss | output | 1 | No valid slot matched |
| res_idx | output | 5 | Winning slot number (0 on a miss) |
| res_act | output | 5 | Action of the winning slot (0 on a miss) |

## Verification
The assertions assume that `lk_valid`, `wr_en` and the other control inputs are driven to known values from time zero. They also assume that no write reaches the table before the first result that follows reset, so that any result seen before the first write must be a miss. The stimulus holds every control input low through reset. It changes inputs only on the falling clock edge and issues its first write well after the internal reset release. Lookups are issued freely, both back-to-back and in the same cycle as writes, because the pipeline never applies backpressure.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int unsigned DEF_ENTRIES = 32;
  localparam int unsigned DEF_KEY_W   = 32;
  localparam int unsigned DEF_ACT_W   = 5;

  // Ternary compare: bits flagged in the ignore mask never cause a mismatch.
  function automatic logic tern_eq(input logic [DEF_KEY_W-1:0] a,
                                   input logic [DEF_KEY_W-1:0] b,
                                   input logic [DEF_KEY_W-1:0] ign);
    return ((a ^ b) & ~ign) == '0;
  endfunction
endpackage

// File: rtl/tmt_slot.sv
module tmt_slot #(
  parameter int unsigned KEY_W  = 32,
  parameter int unsigned ACT_W  = 5,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_clear,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ACT_W-1:0] wr_act,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [KEY_W-1:0] srch_key,
  output logic             hit,
  output logic [ACT_W-1:0] act
);
  logic             sel;
  logic             load;
  logic             vld_q, vld_d;
  logic [KEY_W-1:0] key_q, msk_q;
  logic [ACT_W-1:0] act_q;

  always_comb begin
    sel   = wr_en && (wr_idx == IDX_W'(MY_IDX));
    load  = sel && !wr_clear;
    vld_d = sel ? !wr_clear : vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Payload registers: no reset, loaded only under enable.
  always_ff @(posedge clk) begin
    if (load) begin
      key_q <= wr_key;
      msk_q <= wr_mask;
      act_q <= wr_act;
    end
  end

  always_comb begin
    hit = vld_q && (((srch_key ^ key_q) & ~msk_q) == '0);
    act = act_q;
  end
endmodule

// File: rtl/tmt_prio.sv
module tmt_prio #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     hits,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = |hits;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tern_match_table.sv
module tern_match_table #(
  parameter int unsigned ENTRIES = tmt_pkg::DEF_ENTRIES,
  parameter int unsigned KEY_W   = tmt_pkg::DEF_KEY_W,
  parameter int unsigned ACT_W   = tmt_pkg::DEF_ACT_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_clear,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ACT_W-1:0] wr_act,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [KEY_W-1:0] lk_key,
  output logic             res_valid,
  output logic             res_miss,
  output logic [IDX_W-1:0] res_idx,
  output logic [ACT_W-1:0] res_act
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  logic       irst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign irst_n = rsync_q[1];

  // Table slots.
  logic [ENTRIES-1:0]            hits;
  logic [ENTRIES-1:0][ACT_W-1:0] acts;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tmt_slot #(
      .KEY_W (KEY_W),
      .ACT_W (ACT_W),
      .IDX_W (IDX_W),
      .MY_IDX(g)
    ) u_slot (
      .clk     (clk),
      .rst_n   (irst_n),
      .wr_en   (wr_en),
      .wr_clear(wr_clear),
      .wr_idx  (wr_idx),
      .wr_act  (wr_act),
      .wr_key  (wr_key),
      .wr_mask (wr_mask),
      .srch_key(lk_key),
      .hit     (hits[g]),
      .act     (acts[g])
    );
  end

  logic [IDX_W-1:0] win_idx;
  logic             win_any;

  tmt_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .hits(hits),
    .idx (win_idx),
    .any (win_any)
  );

  // Stage 1 next state: compare, priority pick and action select.
  logic             accept;
  logic             s1_vld_q, s1_vld_d;
  logic             s1_miss_q, s1_miss_d;
  logic [IDX_W-1:0] s1_idx_q, s1_idx_d;
  logic [ACT_W-1:0] s1_act_q, s1_act_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    accept    = lk_valid && rdy_q;
    s1_vld_d  = accept;
    s1_miss_d = !win_any;
    s1_idx_d  = win_any ? win_idx : '0;
    s1_act_d  = win_any ? acts[win_idx] : '0;
    rdy_d     = 1'b1;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      s1_vld_q <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      rdy_q    <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_miss_q <= s1_miss_d;
      s1_idx_q  <= s1_idx_d;
      s1_act_q  <= s1_act_d;
    end
  end

  // Stage 2: output register.
  logic             o_vld_q;
  logic             o_miss_q;
  logic [IDX_W-1:0] o_idx_q;
  logic [ACT_W-1:0] o_act_q;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) o_vld_q <= 1'b0;
    else         o_vld_q <= s1_vld_q;
  end

  always_ff @(posedge clk) begin
    if (s1_vld_q) begin
      o_miss_q <= s1_miss_q;
      o_idx_q  <= s1_idx_q;
      o_act_q  <= s1_act_q;
    end
  end

  assign lk_ready  = rdy_q;
  assign res_valid = o_vld_q;
  assign res_miss  = o_miss_q;
  assign res_idx   = o_idx_q;
  assign res_act   = o_act_q;
endmodule

// File: rtl/tmt_checker.sv
module tmt_checker #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned ACT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             res_valid,
  input logic             res_miss,
  input logic [IDX_W-1:0] res_idx,
  input logic [ACT_W-1:0] res_act
);
  logic wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wrote_q <= 1'b0;
    else if (wr_en) wrote_q <= 1'b1;
  end

  // R7: every accepted lookup yields a result two cycles later.
  a_r7_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> ##1 res_valid);

  // R7: no result appears without an accepted lookup two cycles earlier.
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid && lk_ready, 2));

  // R5: a miss reports zero slot and zero action.
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_idx == '0 && res_act == '0));

  // R1: before any write since reset, results can only be misses.
  a_r1_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !wrote_q) |-> res_miss);

  // R8: once ready, stays ready while reset is released.
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |=> lk_ready);
endmodule

bind tern_match_table tmt_checker #(.IDX_W(IDX_W), .ACT_W(ACT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .res_valid(res_valid),
  .res_miss (res_miss),
  .res_idx  (res_idx),
  .res_act  (res_act)
);

// File: tb/sim_tern_match_table.sv
module sim_tern_match_table;
  localparam int N  = 32;
  localparam int KW = 32;
  localparam int AW = 5;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_clear;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_act;
  logic [KW-1:0] wr_key, wr_mask;
  logic          lk_valid;
  logic          lk_ready;
  logic [KW-1:0] lk_key;
  logic          res_valid, res_miss;
  logic [IW-1:0] res_idx;
  logic [AW-1:0] res_act;

  always #4 clk = ~clk;

  tern_match_table u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_clear(wr_clear), .wr_idx(wr_idx), .wr_act(wr_act),
    .wr_key(wr_key), .wr_mask(wr_mask),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_key(lk_key),
    .res_valid(res_valid), .res_miss(res_miss), .res_idx(res_idx), .res_act(res_act)
  );

  // Reference table built from the requirements.
  logic          m_vld [N];
  logic [KW-1:0] m_key [N];
  logic [KW-1:0] m_msk [N];
  logic [AW-1:0] m_act [N];

  typedef struct {
    int            due;
    logic          miss;
    logic [IW-1:0] idx;
    logic [AW-1:0] act;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic exp_t predict(input logic [KW-1:0] k, input string tag);
    exp_t e;
    e.due = cyc + 2; e.miss = 1'b1; e.idx = '0; e.act = '0; e.tag = tag;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_vld[i] && (((k ^ m_key[i]) & ~m_msk[i]) == '0)) begin
        e.miss = 1'b0; e.idx = IW'(i); e.act = m_act[i];
      end
    end
    return e;
  endfunction

  // Drive one cycle: optional write, optional lookup. Lookup is predicted
  // from the model before the write is applied (R9).
  task automatic cycle_op(input bit dw, input bit clr, input int idx,
                          input logic [AW-1:0] act, input logic [KW-1:0] key,
                          input logic [KW-1:0] msk, input bit dl,
                          input logic [KW-1:0] lkey, input string tag);
    @(negedge clk);
    wr_en = dw; wr_clear = clr; wr_idx = IW'(idx); wr_act = act;
    wr_key = key; wr_mask = msk;
    lk_valid = dl; lk_key = lkey;
    if (dl) q.push_back(predict(lkey, tag));
    if (dw) begin
      m_vld[idx] = !clr;
      if (!clr) begin m_key[idx] = key; m_msk[idx] = msk; m_act[idx] = act; end
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_clear = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [AW-1:0] act,
                    input logic [KW-1:0] key, input logic [KW-1:0] msk);
    cycle_op(1, 0, idx, act, key, msk, 0, '0, "");
  endtask

  task automatic clr(input int idx);
    cycle_op(1, 1, idx, '0, '0, '0, 0, '0, "");
  endtask

  task automatic look(input logic [KW-1:0] k, input string tag);
    cycle_op(0, 0, 0, '0, '0, '0, 1, k, tag);
  endtask

  // Monitor: compares results as they appear.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (res_valid === 1'b1) begin
        if (q.size() == 0) begin
          check("R7", 1'b0, "result with no pending lookup");
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R7", e.due == cyc,
                $sformatf("%s latency: got cycle %0d expected %0d", e.tag, cyc, e.due));
          check(e.tag, (res_miss === e.miss) && (res_idx === e.idx) && (res_act === e.act),
                $sformatf("got miss=%0b idx=%0d act=%0d expected miss=%0b idx=%0d act=%0d",
                          res_miss, res_idx, res_act, e.miss, e.idx, e.act));
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        check("R7", 1'b0, $sformatf("%s result missing at cycle %0d expected %0d", e.tag, cyc, e.due));
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 1'b0; m_key[i] = '0; m_msk[i] = '0; m_act[i] = '0;
    end
    rst_n = 1'b0; wr_en = 1'b0; wr_clear = 1'b0; wr_idx = '0; wr_act = '0;
    wr_key = '0; wr_mask = '0; lk_valid = 1'b0; lk_key = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", lk_ready === 1'b0, $sformatf("ready in reset got %0b expected 0", lk_ready));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", lk_ready === 1'b1, $sformatf("ready after reset got %0b expected 1", lk_ready));

    // R1: empty table.
    look(32'h0000_0000, "R1");
    look(32'h0000_007B, "R1");
    look(32'hFFFF_FFFF, "R1");

    // R2 exact match, R5 miss.
    wr(3, 5'd7, 32'hC0A8_0101, 32'h0);
    look(32'hC0A8_0101, "R2");
    look(32'hC0A8_0102, "R5");

    // R3 masked low byte; R6 overlap with slot 3.
    wr(5, 5'd9, 32'hC0A8_0100, 32'h0000_00FF);
    look(32'hC0A8_01AB, "R3");
    look(32'hC0A8_0101, "R6");
    look(32'hC0A9_01AB, "R3");

    // R6 full wildcard at slot 1 wins everything.
    wr(1, 5'd2, 32'h1234_5678, 32'hFFFF_FFFF);
    look(32'hC0A8_0101, "R6");
    look(32'hDEAD_BEEF, "R6");

    // R4 clear slot 1; stored wildcard no longer matches.
    clr(1);
    look(32'hDEAD_BEEF, "R4");
    look(32'hC0A8_0101, "R4");

    // R9 write and lookup same cycle see old contents.
    cycle_op(1, 0, 0, 5'd4, 32'hAAAA_5555, 32'h0, 1, 32'hAAAA_5555, "R9");
    look(32'hAAAA_5555, "R9");
    cycle_op(1, 1, 0, '0, '0, '0, 1, 32'hAAAA_5555, "R9");
    look(32'hAAAA_5555, "R9");

    // R10 overwrite slot 3.
    wr(3, 5'd30, 32'h0A00_0000, 32'h00FF_FFFF);
    look(32'h0A12_3456, "R10");
    look(32'hC0A8_0101, "R10");

    // R7 back-to-back lookups (one per cycle).
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      lk_valid = 1'b1;
      lk_key = (i % 2 == 0) ? 32'h0A00_0000 + i : 32'hC0A8_0100 + i;
      q.push_back(predict(lk_key, "R7"));
    end
    @(negedge clk);
    lk_valid = 1'b0;

    // Mixed traffic: writes, clears and lookups from a small key pool.
    for (int i = 0; i < 300; i++) begin
      logic [KW-1:0] k, m, lk;
      int            s;
      k  = {28'h5A5A5A5, 4'($urandom_range(0, 15))};
      m  = ($urandom_range(0, 3) == 0) ? 32'h0000_000F :
           ($urandom_range(0, 1) == 0) ? 32'h0000_0003 : 32'h0;
      lk = {28'h5A5A5A5, 4'($urandom_range(0, 15))};
      s  = $urandom_range(0, N - 1);
      cycle_op($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, s,
               AW'($urandom_range(0, 31)), k, m, $urandom_range(0, 1) == 1, lk, "R6");
    end

    repeat (5) @(negedge clk);
    check("R7", q.size() == 0, $sformatf("pending results got %0d expected 0", q.size()));
    check("R8", lk_ready === 1'b1, $sformatf("ready got %0b expected 1", lk_ready));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule